// File: doc/BRIEF.md
# Spread-Spectrum Triangle Ramp Generator

This block produces the slowly varying fractional divide value used when a fractional-N clock synthesizer runs in down-spread spread-spectrum mode. Once per reference-clock cycle, an unsigned 18-bit fraction moves by a programmable increment. It walks down from a top limit to a bottom limit, then back up, and repeats. All 18 bits are fractional, so 2^18 stands for 1.0 of the gap between the two neighbouring integer divide ratios. The top limit is the zero-spread point, and the bottom limit is the largest downward frequency offset. As an example, a 30 MHz reference with ratios 82 and 84 and a 0 to -4500 ppm spread from 2.5 GHz gives a top near 0.6667 (174762) and a bottom near 0.4792 (125611). The increment follows from the span, twice the modulation rate (31.5 kHz) and the reference rate, which gives about 103 codes per cycle. These three values are computed outside the block.

A control state machine has five states:
- `ST_IDLE`: disabled. The output is parked at the top limit.
- `ST_FALL`: descending.
- `ST_AT_LO`: clamped at the bottom limit.
- `ST_RISE`: ascending.
- `ST_AT_HI`: clamped at the top limit.

Its transitions are:
- IDLE→FALL when enable is high.
- FALL→AT_LO when the next decrement would reach or pass the bottom limit.
- AT_LO→RISE unconditionally.
- RISE→AT_HI when the next increment would reach or pass the top limit.
- AT_HI→FALL unconditionally.
- Any state→IDLE when enable is low or reset is asserted.

The limit and increment inputs are captured into working copies only in IDLE and in the two clamp states. A reprogramming therefore never bends a ramp partway through.

Top module: `ssc_tri_gen`

## Requirements
- R1: A synchronous active-low reset makes `frac_out` equal to the `top_frac` value present at that clock edge, with `dir_down` = 1, on the next cycle.
- R2: While in IDLE, including the first enabled cycle, `frac_out` follows `top_frac` with one cycle of delay, and `dir_down` is 1.
- R3: In FALL, while `frac_out` is greater than the working bottom plus the working increment, the next `frac_out` is `frac_out` minus the increment. `dir_down` is 1.
- R4: In FALL, when `frac_out` is at or below the working bottom plus the increment, the next `frac_out` equals the bottom exactly. `dir_down` stays 1 for that cycle, and becomes 0 on the following cycle while the value holds.
- R5: In RISE, while `frac_out` plus the increment is below the working top, the next `frac_out` is `frac_out` plus the increment. `dir_down` is 0.
- R6: In RISE, when `frac_out` plus the increment reaches or exceeds the working top, the next `frac_out` equals the top exactly. `dir_down` stays 0 for that cycle and becomes 1 on the following cycle.
- R7: `bot_frac`, `top_frac` and `step_frac` are sampled only in IDLE and in the clamp cycles. Changes while in FALL or RISE do not affect `frac_out` until the next clamp cycle.
- R8: With fixed limits where bottom ≤ top, an enabled `frac_out` never leaves the range [bottom, top].
- R9: Dropping `enable` in any state returns `frac_out` to `top_frac`, with `dir_down` = 1, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one ramp update per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the ramp when high; park at the top limit when low |
| bot_frac | input | 18 | Bottom limit (maximum down-spread), unsigned, 2^18 = 1.0 |
| top_frac | input | 18 | Top limit (zero spread), unsigned, 2^18 = 1.0 |
| step_frac | input | 18 | Change applied per reference cycle |
| frac_out | output | 18 | Current fractional divide value |
| dir_down | output | 1 | 1 while descending or parked, 0 while ascending |

## Verification
A wrong state or a bad working copy of the limits shows on `frac_out` one cycle after it arises. Typical symptoms are a value stepping past a limit, a missing or extra clamp cycle, or a ramp that picks up a new increment partway through. The bench applies small limits and every increment from 1 to 9 over several spans, so each clamp condition (exact landing and overshoot) is reached many times. A wrong direction decode shows on `dir_down` in the cycle after a clamp. Each cycle's output is compared with an arithmetic model, so any deviation is flagged at the cycle it appears.

// File: rtl/ssc_tri_pkg.sv
package ssc_tri_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FALL  = 3'd1,
        ST_AT_LO = 3'd2,
        ST_RISE  = 3'd3,
        ST_AT_HI = 3'd4
    } ramp_state_t;

endpackage

// File: rtl/ssc_tri_cfg.sv
module ssc_tri_cfg #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] bot_in,
    input  logic [W-1:0] top_in,
    input  logic [W-1:0] step_in,
    output logic [W-1:0] bot_q,
    output logic [W-1:0] top_q,
    output logic [W-1:0] step_q
);

    // Working copies of the programmed limits, refreshed only on load
    always_ff @(posedge clk) begin
        if (load) begin
            bot_q  <= bot_in;
            top_q  <= top_in;
            step_q <= step_in;
        end
    end

endmodule

// File: rtl/ssc_tri_fsm.sv
module ssc_tri_fsm
    import ssc_tri_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        hit_lo,
    input  logic        hit_hi,
    output ramp_state_t state_q
);

    ramp_state_t state_nxt;

    always_comb begin
        state_nxt = state_q;
        if (!enable) begin
            state_nxt = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_nxt = ST_FALL;
                ST_FALL:  state_nxt = hit_lo ? ST_AT_LO : ST_FALL;
                ST_AT_LO: state_nxt = ST_RISE;
                ST_RISE:  state_nxt = hit_hi ? ST_AT_HI : ST_RISE;
                ST_AT_HI: state_nxt = ST_FALL;
                default:  state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    AST_OFF_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_q == ST_IDLE); // R9

    AST_TURN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (state_q == ST_AT_LO)) |=> (state_q == ST_RISE || state_q == ST_IDLE)); // R4

endmodule

// File: rtl/ssc_tri_dp.sv
module ssc_tri_dp
    import ssc_tri_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  ramp_state_t  state_q,
    input  logic [W-1:0] top_in,
    input  logic [W-1:0] bot_q,
    input  logic [W-1:0] top_q,
    input  logic [W-1:0] step_q,
    output logic [W-1:0] frac_q,
    output logic         hit_lo,
    output logic         hit_hi
);

    localparam int WX = W + 1;

    logic [WX-1:0] frac_x, lo_plus, up_next;

    always_comb begin
        frac_x  = {1'b0, frac_q};
        lo_plus = {1'b0, bot_q} + {1'b0, step_q};
        up_next = frac_x + {1'b0, step_q};
        hit_lo  = (frac_x <= lo_plus);
        hit_hi  = (up_next >= {1'b0, top_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            frac_q <= top_in;
        end else begin
            unique case (state_q)
                ST_IDLE:  frac_q <= top_in;
                ST_FALL:  frac_q <= hit_lo ? bot_q : (frac_q - step_q);
                ST_RISE:  frac_q <= hit_hi ? top_q : up_next[W-1:0];
                ST_AT_LO: frac_q <= frac_q;
                ST_AT_HI: frac_q <= frac_q;
                default:  frac_q <= top_in;
            endcase
        end
    end

    AST_FALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_FALL && !hit_lo) |=> frac_q == $past(frac_q) - $past(step_q)); // R3

    AST_CLAMP_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_FALL && hit_lo) |=> frac_q == $past(bot_q)); // R4

    AST_RISE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_RISE && !hit_hi) |=> frac_q == $past(frac_q) + $past(step_q)); // R5

    AST_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_RISE && hit_hi) |=> frac_q == $past(top_q)); // R6

endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
    import ssc_tri_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic [W-1:0] bot_frac,
    input  logic [W-1:0] top_frac,
    input  logic [W-1:0] step_frac,
    output logic [W-1:0] frac_out,
    output logic         dir_down
);

    ramp_state_t  state_q;
    logic         hit_lo, hit_hi, cfg_load;
    logic [W-1:0] bot_q, top_q, step_q;

    // Limits may only change when parked or at a turnaround
    always_comb begin
        cfg_load = !rst_n || !enable ||
                   (state_q == ST_IDLE) || (state_q == ST_AT_LO) || (state_q == ST_AT_HI);
    end

    ssc_tri_cfg #(.W(W)) u_cfg (
        .clk     (clk),
        .load    (cfg_load),
        .bot_in  (bot_frac),
        .top_in  (top_frac),
        .step_in (step_frac),
        .bot_q   (bot_q),
        .top_q   (top_q),
        .step_q  (step_q)
    );

    ssc_tri_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .hit_lo  (hit_lo),
        .hit_hi  (hit_hi),
        .state_q (state_q)
    );

    ssc_tri_dp #(.W(W)) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .state_q (state_q),
        .top_in  (top_frac),
        .bot_q   (bot_q),
        .top_q   (top_q),
        .step_q  (step_q),
        .frac_q  (frac_out),
        .hit_lo  (hit_lo),
        .hit_hi  (hit_hi)
    );

    // Output decode: descending, parked or clamped low read as down
    always_comb begin
        unique case (state_q)
            ST_RISE, ST_AT_HI: dir_down = 1'b0;
            default:           dir_down = 1'b1;
        endcase
    end

    AST_IDLE_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (frac_out == top_q)); // R2

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (state_q == ST_FALL || state_q == ST_RISE))
        |=> ($stable(bot_q) && $stable(top_q) && $stable(step_q))); // R7

    AST_UP_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_AT_LO) |-> dir_down); // R4

    AST_DOWN_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == ST_AT_HI) |=> (dir_down || !enable)); // R6

endmodule

// File: tb/test_ssc_tri_gen.sv
module test_ssc_tri_gen;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic [W-1:0] bot_frac = '0;
    logic [W-1:0] top_frac = '0;
    logic [W-1:0] step_frac = '0;
    logic [W-1:0] frac_out;
    logic         dir_down;

    always #2 clk = ~clk;

    ssc_tri_gen #(.W(W)) i_ssc_tri_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .bot_frac  (bot_frac),
        .top_frac  (top_frac),
        .step_frac (step_frac),
        .frac_out  (frac_out),
        .dir_down  (dir_down)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // Model: 0 parked, 1 down, 2 low clamp, 3 up, 4 high clamp
    int m_frac = 0, m_mode = 0, m_lo = 0, m_hi = 0, m_st = 0;
    int prev_mode = 0;
    bit prev_rst = 1'b0, prev_en = 1'b0, prev_chg = 1'b0;

    task automatic model_next();
        prev_mode = m_mode;
        prev_rst  = rst_n;
        prev_en   = enable;
        prev_chg  = (int'(step_frac) != m_st);
        if (!rst_n || !enable) begin
            m_frac = int'(top_frac); m_mode = 0;
            m_lo = int'(bot_frac); m_hi = int'(top_frac); m_st = int'(step_frac);
        end else begin
            case (m_mode)
                0: begin
                    m_frac = int'(top_frac); m_mode = 1;
                    m_lo = int'(bot_frac); m_hi = int'(top_frac); m_st = int'(step_frac);
                end
                1: if (m_frac <= m_lo + m_st) begin m_frac = m_lo; m_mode = 2; end
                   else m_frac = m_frac - m_st;
                2: begin
                    m_mode = 3;
                    m_lo = int'(bot_frac); m_hi = int'(top_frac); m_st = int'(step_frac);
                end
                3: if (m_frac + m_st >= m_hi) begin m_frac = m_hi; m_mode = 4; end
                   else m_frac = m_frac + m_st;
                default: begin
                    m_mode = 1;
                    m_lo = int'(bot_frac); m_hi = int'(top_frac); m_st = int'(step_frac);
                end
            endcase
        end
    endtask

    task automatic compare();
        string tag;
        bit    exp_dir;
        exp_dir = !(m_mode == 3 || m_mode == 4);
        if (!prev_rst)                    tag = "R1";
        else if (!prev_en)                tag = (prev_mode == 0) ? "R2" : "R9";
        else if (prev_mode == 0)          tag = "R2";
        else if (prev_mode == 1)          tag = (m_mode == 2) ? "R4" : (prev_chg ? "R7" : "R3");
        else if (prev_mode == 3)          tag = (m_mode == 4) ? "R6" : (prev_chg ? "R7" : "R5");
        else                              tag = (prev_mode == 2) ? "R4" : "R6";
        vectors++;
        if (frac_out !== m_frac[W-1:0] || dir_down !== exp_dir) begin
            miscompares++;
            $display("FAIL %s: frac=%0d dir=%0b expected frac=%0d dir=%0b",
                     tag, frac_out, dir_down, m_frac, exp_dir);
        end
        if (m_mode != 0 && m_lo <= m_hi) begin
            vectors++;
            if (int'(frac_out) < m_lo || int'(frac_out) > m_hi) begin
                miscompares++;
                $display("FAIL R8: frac=%0d expected within %0d..%0d", frac_out, m_lo, m_hi);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_next();
        @(negedge clk);
        compare();
    endtask

    task automatic run_cfg(input int lo, input int hi, input int st, input int n, input bit perturb);
        bot_frac = lo[W-1:0]; top_frac = hi[W-1:0]; step_frac = st[W-1:0];
        enable = 1'b0;
        tick(); tick();
        enable = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (perturb && (i % 7 == 3)) step_frac = W'(st + 1 + (i % 3));
            else                         step_frac = st[W-1:0];
            tick();
        end
        enable = 1'b0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        bot_frac = 18'd7; top_frac = 18'd30; step_frac = 18'd3;
        @(negedge clk);
        tick(); tick(); tick();
        rst_n = 1'b1;
        // Sweep: several bases, spans and every small increment
        for (int b = 0; b < 3; b++) begin
            for (int s = 0; s < 3; s++) begin
                for (int st = 1; st <= 9; st++) begin
                    int lo, hi;
                    lo = (b == 0) ? 0 : ((b == 1) ? 5 : 100);
                    hi = lo + ((s == 0) ? 1 : ((s == 1) ? 7 : 40));
                    run_cfg(lo, hi, st, 4 * ((hi - lo) / st + 3) + 4, (st % 2) == 1);
                end
            end
        end
        // Increment larger than the span
        run_cfg(10, 12, 50, 20, 1'b0);
        // Realistic setting: 30 MHz reference, 82/84 ratios
        run_cfg(125611, 174762, 103, 2000, 1'b0);
        // Reset in the middle of a ramp
        bot_frac = 18'd20; top_frac = 18'd60; step_frac = 18'd4;
        enable = 1'b1;
        for (int i = 0; i < 9; i++) tick();
        rst_n = 1'b0; tick();
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) tick();
        enable = 1'b0; tick();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule